// File: doc/BRIEF.md
# Sequential Next-PC Unit

This block owns the program counter of a single-cycle processor core. On every rising clock edge it loads one of three candidate addresses: the next sequential word, a PC-relative branch destination whose 16-bit signed offset counts in words, or a pseudo-absolute jump destination. The jump destination takes its 26-bit word index from the instruction and its top bits from the incremented PC. The current PC drives the instruction fetch address. The incremented value is also exported, for example for link-register writes.

Decode logic supplies the branch request and the ALU equality flag separately, and a jump request. The unit combines them with a fixed priority: jump first, then taken branch, then sequential. The immediate and jump-index fields are wired straight from the fetched instruction. The unit performs no decode of its own.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the PC loads 0x00000000, whatever the other inputs are.
- R2: With `jump_req` low and no taken branch, the PC advances by 4 at each rising edge, wrapping modulo 2^32.
- R3: `pc_plus4` always equals `pc_q` + 4 (modulo 2^32).
- R4: When `branch_req` and `zero_flag` are both high and `jump_req` is low, the next PC is `pc_q` + 4 + (`imm_field` sign-extended from bit 15, multiplied by 4).
- R5: A branch request with `zero_flag` low, or `zero_flag` high without a branch request, leaves the PC on the sequential path (`pc_q` + 4).
- R6: A taken branch with `imm_field` = 0xFFFF goes backward one word, so the next PC equals the current PC.
- R7: When `jump_req` is high, the next PC is {`pc_plus4`[31:28], `jump_field`[25:0], 2'b00}.
- R8: When `jump_req` and a taken branch coincide, the jump destination of R7 is loaded.
- R9: `pc_q` changes only at a rising edge of `clk`. Input changes between edges leave it unchanged.
- R10: The upper four bits of a jump destination come from the incremented PC, so a jump issued from the last word of a 256 MB region lands in the following region.
- R11: Outside reset, `pc_q` is always word aligned (bits 1:0 are zero).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| branch_req | input | 1 | Current instruction is a conditional branch |
| zero_flag | input | 1 | ALU equality flag for the branch compare |
| jump_req | input | 1 | Current instruction is an unconditional jump |
| imm_field | input | 16 | Signed branch offset in words |
| jump_field | input | 26 | Word index of the jump destination within its region |
| pc_q | output | 32 | Current program counter, the fetch address |
| pc_plus4 | output | 32 | Current program counter plus 4 |

## Verification
The hardest case to reach from the ports is a jump issued from the last word of a 256 MB region. Only there do the upper bits of PC and PC+4 differ, so only there does taking the region from the wrong one of the two show. Branch steps move the PC too little to reach that point. The stimulus therefore first jumps with an all-ones index to land on 0x0FFFFFFC, jumps again from there, and later steps sequentially across the next region boundary. A behavioural reference model then follows several hundred cycles of mixed random requests and offsets, covering both polarities of the offset and the coincident jump-and-branch case.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int unsigned PC_W       = 32;
    localparam int unsigned IMM_W      = 16;
    localparam int unsigned JF_W       = 26;
    localparam int unsigned WORD_BYTES = 4;
    localparam int unsigned ALIGN_W    = $clog2(WORD_BYTES);
    localparam int unsigned REGION_W   = PC_W - JF_W - ALIGN_W;

    typedef logic [PC_W-1:0] pc_t;

    // Which candidate feeds the PC register on the next edge
    typedef enum logic [1:0] {
        SRC_SEQ    = 2'd0,
        SRC_BRANCH = 2'd1,
        SRC_JUMP   = 2'd2
    } npc_src_e;

    typedef struct packed {
        pc_t seq;
        pc_t branch;
        pc_t jump;
    } npc_cand_t;

    // Priority: jump over taken branch over sequential
    function automatic npc_src_e pick_src(input logic jmp, input logic br, input logic z);
        if (jmp)
            return SRC_JUMP;
        else if (br && z)
            return SRC_BRANCH;
        else
            return SRC_SEQ;
    endfunction

endpackage

// File: rtl/npc_incr.sv
module npc_incr
    import npc_pkg::*;
#(
    parameter int unsigned W    = PC_W,
    parameter int unsigned STEP = WORD_BYTES
) (
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] seq_o
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    always_comb begin
        seq_o = pc_i + STEP_V;
    end
endmodule

// File: rtl/npc_branch_calc.sv
module npc_branch_calc
    import npc_pkg::*;
#(
    parameter int unsigned W     = PC_W,
    parameter int unsigned IW    = IMM_W,
    parameter int unsigned SHIFT = ALIGN_W
) (
    input  logic [W-1:0]  seq_i,
    input  logic [IW-1:0] imm_i,
    output logic [W-1:0]  target_o
);
    localparam int unsigned EXT_W = W - IW - SHIFT;

    logic [W-1:0] offset;

    generate
        if (EXT_W > 0) begin : g_ext
            always_comb offset = {{EXT_W{imm_i[IW-1]}}, imm_i, {SHIFT{1'b0}}};
        end else begin : g_noext
            always_comb offset = W'({imm_i, {SHIFT{1'b0}}});
        end
    endgenerate

    always_comb begin
        target_o = seq_i + offset;
    end
endmodule

// File: rtl/npc_jump_calc.sv
module npc_jump_calc
    import npc_pkg::*;
#(
    parameter int unsigned W     = PC_W,
    parameter int unsigned FW    = JF_W,
    parameter int unsigned SHIFT = ALIGN_W,
    localparam int unsigned RW   = W - FW - SHIFT
) (
    input  logic [RW-1:0] region_i,
    input  logic [FW-1:0] field_i,
    output logic [W-1:0]  target_o
);
    always_comb begin
        target_o = {region_i, field_i, {SHIFT{1'b0}}};
    end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [PC_W-1:0] RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             branch_req,
    input  logic             zero_flag,
    input  logic             jump_req,
    input  logic [IMM_W-1:0] imm_field,
    input  logic [JF_W-1:0]  jump_field,
    output logic [PC_W-1:0]  pc_q,
    output logic [PC_W-1:0]  pc_plus4
);
    npc_cand_t cand;
    npc_src_e  src;
    pc_t       pc_next;

    npc_incr #(.W(PC_W), .STEP(WORD_BYTES)) u_incr (
        .pc_i  (pc_q),
        .seq_o (cand.seq)
    );

    npc_branch_calc #(.W(PC_W), .IW(IMM_W), .SHIFT(ALIGN_W)) u_branch (
        .seq_i    (cand.seq),
        .imm_i    (imm_field),
        .target_o (cand.branch)
    );

    npc_jump_calc #(.W(PC_W), .FW(JF_W), .SHIFT(ALIGN_W)) u_jump (
        .region_i (cand.seq[PC_W-1 -: REGION_W]),
        .field_i  (jump_field),
        .target_o (cand.jump)
    );

    always_comb begin
        src = pick_src(jump_req, branch_req, zero_flag);
        unique case (src)
            SRC_JUMP:   pc_next = cand.jump;
            SRC_BRANCH: pc_next = cand.branch;
            default:    pc_next = cand.seq;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pc_q <= RESET_PC;
        else
            pc_q <= pc_next;
    end

    assign pc_plus4 = cand.seq;

    // R1: reset loads the start address
    a_r1_reset_load: assert property (@(posedge clk) rst |=> pc_q == RESET_PC);

    // R2 and R5: no jump and no taken branch means sequential advance
    a_r2_sequential: assert property (@(posedge clk) disable iff (rst)
        (!jump_req && !(branch_req && zero_flag)) |=> pc_q == $past(pc_q) + 32'd4);

    // R6: offset of minus one word returns to the same PC
    a_r6_back_one: assert property (@(posedge clk) disable iff (rst)
        (!jump_req && branch_req && zero_flag && imm_field == 16'hFFFF) |=> $stable(pc_q));

    // R7 and R10: jump region taken from the incremented PC
    a_r7_jump_region: assert property (@(posedge clk) disable iff (rst)
        jump_req |=> pc_q[31:28] == $past(pc_q + 32'd4) >> 28);

    // R8: jump index wins even with a taken branch
    a_r8_jump_first: assert property (@(posedge clk) disable iff (rst)
        jump_req |=> pc_q[27:2] == $past(jump_field));

    // R11: fetch address stays word aligned
    a_r11_aligned: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> pc_q[1:0] == 2'b00);

endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        branch_req = 1'b0;
    logic        zero_flag = 1'b0;
    logic        jump_req = 1'b0;
    logic [15:0] imm_field = '0;
    logic [25:0] jump_field = '0;
    logic [31:0] pc_q;
    logic [31:0] pc_plus4;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] model_pc;

    always #5 clk = ~clk;

    npc_unit dut (
        .clk(clk), .rst(rst), .branch_req(branch_req), .zero_flag(zero_flag),
        .jump_req(jump_req), .imm_field(imm_field), .jump_field(jump_field),
        .pc_q(pc_q), .pc_plus4(pc_plus4)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Behavioural reference: integer arithmetic on the PC
    function automatic logic [31:0] ref_next(input logic [31:0] pc, input logic br, input logic z,
                                             input logic j, input logic [15:0] imm, input logic [25:0] jf);
        longint p4;
        longint off;
        p4 = (longint'(pc) + 4) % 64'h1_0000_0000;
        if (j)
            return ((p4 / 32'h1000_0000) * 32'h1000_0000) + longint'(jf) * 4;
        if (br && z) begin
            off = longint'($signed(imm)) * 4;
            return 32'((p4 + off) & 64'hFFFF_FFFF);
        end
        return 32'(p4);
    endfunction

    // Called at a falling edge; applies one cycle of inputs
    task automatic step(input string tag, input logic br, input logic z, input logic j,
                        input logic [15:0] imm, input logic [25:0] jf);
        logic [31:0] exp;
        check("R3 incremented output", pc_plus4, model_pc + 32'd4);
        branch_req = br; zero_flag = z; jump_req = j; imm_field = imm; jump_field = jf;
        exp = ref_next(model_pc, br, z, j, imm, jf);
        #2;
        check("R9 hold between edges", pc_q, model_pc);
        @(posedge clk);
        @(negedge clk);
        check(tag, pc_q, exp);
        check("R11 alignment", {30'd0, pc_q[1:0]}, 32'd0);
        model_pc = exp;
    endtask

    initial begin : watchdog
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R1 reset value", pc_q, 32'h0);
        rst = 1'b0;
        model_pc = 32'h0;

        step("R2 sequential",           0, 0, 0, 16'h0005, 26'h0);       // 0x4
        step("R5 branch without zero",  1, 0, 0, 16'h0005, 26'h0);       // 0x8
        step("R5 zero without branch",  0, 1, 0, 16'h0005, 26'h0);       // 0xC
        step("R4 forward branch",       1, 1, 0, 16'h0003, 26'h0);       // 0x1C
        step("R6 offset minus one",     1, 1, 0, 16'hFFFF, 26'h0);       // 0x1C
        step("R4 backward branch",      1, 1, 0, 16'hFFFE, 26'h0);       // 0x18
        step("R7 jump",                 0, 0, 1, 16'h0000, 26'h100);     // 0x400
        step("R8 jump beats branch",    1, 1, 1, 16'h0007, 26'h20);      // 0x80
        step("R7 jump to region end",   0, 0, 1, 16'h0000, 26'h3FFFFFF); // 0x0FFFFFFC
        step("R10 jump across region",  0, 0, 1, 16'h0000, 26'h10);      // 0x10000040
        step("R7 jump to region end",   0, 0, 1, 16'h0000, 26'h3FFFFFF); // 0x1FFFFFFC
        step("R2 sequential crossing",  0, 0, 0, 16'h0000, 26'h0);       // 0x20000000
        step("R4 large backward",       1, 1, 0, 16'h8000, 26'h0);       // 0x1FFE0004

        for (int i = 0; i < 400; i++) begin
            logic br, z, j;
            logic [15:0] imm;
            logic [25:0] jf;
            string tag;
            br  = 1'($urandom);
            z   = 1'($urandom);
            j   = ($urandom % 8) == 0;
            imm = 16'($urandom);
            jf  = 26'($urandom);
            if (j)            tag = (br && z) ? "R8 random" : "R7 random";
            else if (br && z) tag = "R4 random";
            else              tag = "R5 random";
            step(tag, br, z, j, imm, jf);
        end

        // Reset overrides a simultaneous jump request
        rst = 1'b1; jump_req = 1'b1; jump_field = 26'h155; branch_req = 1'b1; zero_flag = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset over jump", pc_q, 32'h0);
        rst = 1'b0; jump_req = 1'b0; branch_req = 1'b0; zero_flag = 1'b0;
        model_pc = 32'h0;
        step("R2 after reset", 0, 0, 0, 16'h0, 26'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule